// File: doc/BRIEF.md
# Snooping Cache Line State Controller

This block keeps the coherence state of the cache lines owned by one processor in a four-processor snooping system. Processor loads and stores are looked up in a small direct-mapped table of tags and line states. A hit either completes at once or, for a store to a shared line, first asks the system for ownership. A miss sends a fill request of the right strength to the external agent. When the line comes back, the block installs it in a state chosen by the request type and by the shared flag that comes with the data.

A second port serves the external agent while it probes this processor on behalf of other processors' reads. The block reports the probed line's current state, including whether it holds the only modified copy, and then demotes or drops the line depending on whether the remote read wanted ownership. Only one miss or ownership request is in flight at a time. The processor sees a busy flag until that request resolves.

Top module: `cline_ctrl`

## Requirements
- R1: After reset every line is invalid, `ext_req_valid` and `cpu_done` are low, and `cpu_busy` is low while `ivn_valid` is low.
- R2: A load that misses raises `ext_req_valid` with `ext_req_kind` = 00 (plain read) and `ext_req_addr` equal to the load address, from the cycle after acceptance until the fill arrives.
- R3: A fill for a plain read installs the line as clean exclusive (10) when `ext_fill_shared` is 0 and as shared (01) when it is 1. `cpu_done` pulses in the cycle after the fill and the request drops.
- R4: A store that misses issues `ext_req_kind` = 01 (read with exclusivity), and its fill installs the line as dirty exclusive (11) whatever `ext_fill_shared` says.
- R5: A store that hits a shared line issues `ext_req_kind` = 10 (invalidate) and keeps it raised until `ext_inv_ack`. Only then does the line become dirty exclusive (11), with `cpu_done` in the following cycle.
- R6: A load hit, or a store hit on a clean or dirty exclusive line, raises no external request and pulses `cpu_done` one cycle after acceptance. A store hit on a clean exclusive line silently becomes dirty exclusive.
- R7: While `ivn_valid` is high, `ivn_state` shows the probed line's state in the same cycle (00 when the tag differs or the line is invalid), and `ivn_takeover` is high exactly when that state is dirty exclusive (11). Both outputs are 0 when `ivn_valid` is low.
- R8: A probe with `ivn_excl` = 1 invalidates a matching line. A probe with `ivn_excl` = 0 leaves a matching line shared (01).
- R9: Only one request is outstanding. `cpu_valid` is ignored while `cpu_busy` is high, and `cpu_busy` is high whenever a request is pending or `ivn_valid` is high.
- R10: If an exclusive probe takes the pending line while an invalidate waits for its acknowledge, the request turns into a read with exclusivity (01) for the same address. Its fill then installs dirty exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_busy | output | 1 | Request not accepted this cycle |
| cpu_done | output | 1 | Access completed (one-cycle pulse) |
| ext_req_valid | output | 1 | Request to external agent pending |
| ext_req_kind | output | 2 | 00 read, 01 read exclusive, 10 invalidate |
| ext_req_addr | output | ADDR_W | Address of pending request |
| ext_fill_valid | input | 1 | Fill returned for pending read |
| ext_fill_shared | input | 1 | Shared indication with the fill |
| ext_inv_ack | input | 1 | Invalidate acknowledged |
| ivn_valid | input | 1 | Intervention probe present |
| ivn_excl | input | 1 | Probe is for a read exclusive |
| ivn_addr | input | ADDR_W | Probed line address |
| ivn_state | output | 2 | State of the probed line |
| ivn_takeover | output | 1 | Probed line is dirty exclusive |

## Verification
The hardest case to reach is the race in R10. A store has found its line shared and is waiting for the invalidate acknowledge when an exclusive probe for that same line arrives. The bench first fills a line as shared and issues a store to it. While `ext_req_kind` reads invalidate, and with the acknowledge held back, it drives the exclusive probe and then checks that the request turns into a read with exclusivity and that the later fill leaves the line dirty. A behavioural model in the bench follows every cycle, so the busy gating of R9 during probes and pending requests is compared continuously.

// File: rtl/cline_pkg.sv
package cline_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHR = 2'b01,
      LS_CLN = 2'b10,
      LS_DRT = 2'b11
   } lstate_e;

   typedef enum logic [1:0] {
      RK_READ  = 2'b00,
      RK_READX = 2'b01,
      RK_INVAL = 2'b10
   } rkind_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'b00,
      SQ_WFILL = 2'b01,
      SQ_WINV  = 2'b10
   } seq_e;
endpackage

// File: rtl/cline_table.sv
module cline_table
   import cline_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int TAG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [TAG_W-1:0] a_tag,
   output lstate_e          a_state,
   output logic             a_hit,
   input  logic [IDX_W-1:0] b_idx,
   input  logic [TAG_W-1:0] b_tag,
   output lstate_e          b_state,
   output logic             b_hit,
   input  logic             ivn_we,
   input  lstate_e          ivn_st,
   input  logic             loc_we,
   input  logic [IDX_W-1:0] loc_idx,
   input  logic [TAG_W-1:0] loc_tag,
   input  lstate_e          loc_st
);
   localparam int SETS = 1 << IDX_W;

   logic [TAG_W-1:0] tag_v [SETS];
   lstate_e          st_v  [SETS];

   for (genvar g = 0; g < SETS; g++) begin : g_set
      logic [TAG_W-1:0] t_q;
      lstate_e          s_q;
      logic             loc_sel, ivn_sel;

      assign loc_sel = loc_we && (loc_idx == IDX_W'(g));
      assign ivn_sel = ivn_we && (b_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            t_q <= '0;
            s_q <= LS_INV;
         end else if (loc_sel) begin
            t_q <= loc_tag;
            s_q <= loc_st;
         end else if (ivn_sel) begin
            s_q <= ivn_st;
         end
      end

      assign tag_v[g] = t_q;
      assign st_v[g]  = s_q;
   end

   assign a_state = st_v[a_idx];
   assign a_hit   = (st_v[a_idx] != LS_INV) && (tag_v[a_idx] == a_tag);
   assign b_state = st_v[b_idx];
   assign b_hit   = (st_v[b_idx] != LS_INV) && (tag_v[b_idx] == b_tag);
endmodule

// File: rtl/cline_seq.sv
module cline_seq
   import cline_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_store,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              ivn_valid,
   input  logic              ivn_excl,
   input  logic [ADDR_W-1:0] ivn_addr,
   input  logic              ivn_hit,
   input  logic              look_hit,
   input  lstate_e           look_state,
   input  logic              fill_valid,
   input  logic              fill_shared,
   input  logic              inv_ack,
   output logic [ADDR_W-1:0] look_addr,
   output logic              busy,
   output logic              done,
   output logic              req_valid,
   output rkind_e            req_kind,
   output logic [ADDR_W-1:0] req_addr,
   output logic              loc_we,
   output logic [ADDR_W-1:0] loc_addr,
   output lstate_e           loc_st
);
   seq_e              sq_q;
   logic [ADDR_W-1:0] pend_q;
   logic              store_q;
   rkind_e            kind_q;
   logic              done_q;

   logic accept, up_hit, ld_hit, lost, fill_go, ack_go;

   assign accept  = (sq_q == SQ_IDLE) && cpu_valid && !ivn_valid;
   assign ld_hit  = accept && look_hit && !cpu_store;
   assign up_hit  = accept && look_hit && cpu_store && (look_state != LS_SHR);
   assign lost    = (sq_q == SQ_WINV) && ivn_valid && ivn_excl && ivn_hit
                    && (ivn_addr == pend_q);
   assign fill_go = (sq_q == SQ_WFILL) && fill_valid;
   assign ack_go  = (sq_q == SQ_WINV) && inv_ack && !lost;

   assign look_addr = (sq_q == SQ_IDLE) ? cpu_addr : pend_q;

   always_comb begin
      loc_we   = 1'b0;
      loc_addr = pend_q;
      loc_st   = LS_DRT;
      if (up_hit) begin
         loc_we   = 1'b1;
         loc_addr = cpu_addr;
      end else if (fill_go) begin
         loc_we = 1'b1;
         if (!store_q) loc_st = fill_shared ? LS_SHR : LS_CLN;
      end else if (ack_go) begin
         loc_we = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q    <= SQ_IDLE;
         pend_q  <= '0;
         store_q <= 1'b0;
         kind_q  <= RK_READ;
         done_q  <= 1'b0;
      end else begin
         done_q <= ld_hit || up_hit || fill_go || ack_go;
         unique case (sq_q)
            SQ_IDLE: begin
               if (accept && !(ld_hit || up_hit)) begin
                  pend_q  <= cpu_addr;
                  store_q <= cpu_store;
                  if (look_hit) begin
                     kind_q <= RK_INVAL;
                     sq_q   <= SQ_WINV;
                  end else begin
                     kind_q <= cpu_store ? RK_READX : RK_READ;
                     sq_q   <= SQ_WFILL;
                  end
               end
            end
            SQ_WFILL: if (fill_go) sq_q <= SQ_IDLE;
            SQ_WINV: begin
               if (lost) begin
                  kind_q <= RK_READX;
                  sq_q   <= SQ_WFILL;
               end else if (ack_go) begin
                  sq_q <= SQ_IDLE;
               end
            end
            default: sq_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (sq_q != SQ_IDLE) || ivn_valid;
   assign done      = done_q;
   assign req_valid = (sq_q != SQ_IDLE);
   assign req_kind  = kind_q;
   assign req_addr  = pend_q;
endmodule

// File: rtl/cline_ctrl.sv
module cline_ctrl
   import cline_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int IDX_W   = 3,
   parameter bit RSP_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_store,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              ext_req_valid,
   output logic [1:0]        ext_req_kind,
   output logic [ADDR_W-1:0] ext_req_addr,
   input  logic              ext_fill_valid,
   input  logic              ext_fill_shared,
   input  logic              ext_inv_ack,
   input  logic              ivn_valid,
   input  logic              ivn_excl,
   input  logic [ADDR_W-1:0] ivn_addr,
   output logic [1:0]        ivn_state,
   output logic              ivn_takeover
);
   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 8 && IDX_W < ADDR_W)
         else $fatal(1, "cline_ctrl: IDX_W out of range");
   end

   logic [ADDR_W-1:0] look_addr, loc_addr;
   lstate_e           look_state, b_state, loc_st, ivn_st;
   logic              look_hit, b_hit, loc_we, ivn_we;
   rkind_e            kind;

   assign ivn_we = ivn_valid && b_hit;
   assign ivn_st = ivn_excl ? LS_INV : LS_SHR;

   cline_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_idx   (look_addr[IDX_W-1:0]),
      .a_tag   (look_addr[ADDR_W-1:IDX_W]),
      .a_state (look_state),
      .a_hit   (look_hit),
      .b_idx   (ivn_addr[IDX_W-1:0]),
      .b_tag   (ivn_addr[ADDR_W-1:IDX_W]),
      .b_state (b_state),
      .b_hit   (b_hit),
      .ivn_we  (ivn_we),
      .ivn_st  (ivn_st),
      .loc_we  (loc_we),
      .loc_idx (loc_addr[IDX_W-1:0]),
      .loc_tag (loc_addr[ADDR_W-1:IDX_W]),
      .loc_st  (loc_st)
   );

   cline_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_valid   (cpu_valid),
      .cpu_store   (cpu_store),
      .cpu_addr    (cpu_addr),
      .ivn_valid   (ivn_valid),
      .ivn_excl    (ivn_excl),
      .ivn_addr    (ivn_addr),
      .ivn_hit     (b_hit),
      .look_hit    (look_hit),
      .look_state  (look_state),
      .fill_valid  (ext_fill_valid),
      .fill_shared (ext_fill_shared),
      .inv_ack     (ext_inv_ack),
      .look_addr   (look_addr),
      .busy        (cpu_busy),
      .done        (cpu_done),
      .req_valid   (ext_req_valid),
      .req_kind    (kind),
      .req_addr    (ext_req_addr),
      .loc_we      (loc_we),
      .loc_addr    (loc_addr),
      .loc_st      (loc_st)
   );

   assign ext_req_kind = kind;

   lstate_e rsp_now;
   assign rsp_now = (ivn_valid && b_hit) ? b_state : LS_INV;

   if (RSP_REG) begin : g_rsp_reg
      lstate_e rsp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rsp_q <= LS_INV;
         else        rsp_q <= rsp_now;
      end
      assign ivn_state    = rsp_q;
      assign ivn_takeover = (rsp_q == LS_DRT);
   end else begin : g_rsp_comb
      assign ivn_state    = rsp_now;
      assign ivn_takeover = (rsp_now == LS_DRT);
   end
endmodule

// File: rtl/cline_chk.sv
module cline_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_busy,
   input logic              cpu_done,
   input logic              ext_req_valid,
   input logic [1:0]        ext_req_kind,
   input logic              ext_fill_valid,
   input logic              ext_inv_ack
);
   // R9: a pending request always stalls the processor port
   p_busy_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req_valid |-> cpu_busy);

   // R2 / R4 / R5: only the three legal request kinds appear
   p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req_valid |-> (ext_req_kind != 2'b11));

   // R5: an invalidate stays raised until acknowledged
   p_inv_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req_valid && ext_req_kind == 2'b10 && !ext_inv_ack) |=> ext_req_valid);

   // R3: a fill ends the request and completes the access
   p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req_valid && ext_req_kind != 2'b10 && ext_fill_valid)
      |=> (!ext_req_valid && cpu_done));

   // R5: a request never drops without completing the access
   p_drop_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_req_valid) |-> cpu_done);
endmodule

bind cline_ctrl cline_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_busy       (cpu_busy),
   .cpu_done       (cpu_done),
   .ext_req_valid  (ext_req_valid),
   .ext_req_kind   (ext_req_kind),
   .ext_fill_valid (ext_fill_valid),
   .ext_inv_ack    (ext_inv_ack)
);

// File: tb/tb_cline_ctrl.sv
`timescale 1ns/1ps
module tb_cline_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 0, cpu_store = 0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_busy, cpu_done, ext_req_valid;
   logic [1:0]  ext_req_kind;
   logic [15:0] ext_req_addr;
   logic        ext_fill_valid = 0, ext_fill_shared = 0, ext_inv_ack = 0;
   logic        ivn_valid = 0, ivn_excl = 0;
   logic [15:0] ivn_addr = '0;
   logic [1:0]  ivn_state;
   logic        ivn_takeover;

   always #5 clk = ~clk;

   cline_ctrl dut (.*);

   int total = 0, bad = 0;
   string cur = "R1";
   bit cmp_on = 0, ended = 0;

   // behavioural model: 8 sets, index = addr[2:0]
   int m_tag[8], m_st[8];
   int m_fsm = 0, m_pend = 0, m_kind = 0;
   bit m_store = 0, m_done = 0;

   function automatic bit m_hit(int a);
      return (m_st[a % 8] != 0) && (m_tag[a % 8] == a / 8);
   endfunction

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (cmp_on && !ended) begin
      int ist;
      ist = (ivn_valid && m_hit(int'(ivn_addr))) ? m_st[ivn_addr % 8] : 0;
      chk("busy", cpu_busy, (m_fsm != 0) || ivn_valid);
      chk("done", cpu_done, m_done);
      chk("req_valid", ext_req_valid, m_fsm != 0);
      if (m_fsm != 0) begin
         chk("req_kind", ext_req_kind, m_kind);
         chk("req_addr", ext_req_addr, m_pend);
      end
      chk("ivn_state", ivn_state, ist);
      chk("ivn_takeover", ivn_takeover, ist == 3);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_st[i]) begin m_st[i] = 0; m_tag[i] = 0; end
         m_fsm = 0; m_done = 0; m_kind = 0; m_pend = 0;
      end else begin
         bit ivh, lost;
         int a;
         ivh  = ivn_valid && m_hit(int'(ivn_addr));
         lost = (m_fsm == 2) && ivn_valid && ivn_excl && ivh && (int'(ivn_addr) == m_pend);
         m_done = 0;
         a = int'(cpu_addr);
         if (m_fsm == 0 && cpu_valid && !ivn_valid) begin
            if (m_hit(a) && !cpu_store) m_done = 1;
            else if (m_hit(a) && m_st[a % 8] != 1) begin m_st[a % 8] = 3; m_done = 1; end
            else begin
               m_pend = a; m_store = cpu_store;
               if (m_hit(a)) begin m_kind = 2; m_fsm = 2; end
               else begin m_kind = cpu_store ? 1 : 0; m_fsm = 1; end
            end
         end else if (m_fsm == 1 && ext_fill_valid) begin
            if (ivh) m_st[ivn_addr % 8] = ivn_excl ? 0 : 1;
            m_tag[m_pend % 8] = m_pend / 8;
            m_st[m_pend % 8] = m_store ? 3 : (ext_fill_shared ? 1 : 2);
            m_done = 1; m_fsm = 0;
            ivh = 0;
         end else if (m_fsm == 2) begin
            if (ivh) m_st[ivn_addr % 8] = ivn_excl ? 0 : 1;
            ivh = 0;
            if (lost) begin m_kind = 1; m_fsm = 1; end
            else if (ext_inv_ack) begin m_st[m_pend % 8] = 3; m_done = 1; m_fsm = 0; end
         end
         if (ivh) m_st[ivn_addr % 8] = ivn_excl ? 0 : 1;
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cpu(bit st, int a);
      cpu_valid = 1; cpu_store = st; cpu_addr = 16'(a);
      step();
      cpu_valid = 0;
   endtask

   task automatic fill(bit sh);
      ext_fill_valid = 1; ext_fill_shared = sh;
      step();
      ext_fill_valid = 0; ext_fill_shared = 0;
   endtask

   task automatic probe(bit ex, int a);
      ivn_valid = 1; ivn_excl = ex; ivn_addr = 16'(a);
      step();
      ivn_valid = 0; ivn_excl = 0;
   endtask

   task automatic finish_run();
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      step(3);
      rst_n = 1;
      cmp_on = 1;
      cur = "R1"; step(2); probe(0, 'h0010); step();

      cur = "R2"; cpu(0, 'h0010); step(3);
      cur = "R3"; fill(0); step(2);
      cur = "R7"; probe(0, 'h0010);
      cur = "R8"; probe(0, 'h0010); step();

      cur = "R3"; cpu(0, 'h0021); step(2); fill(1); step();
      cur = "R5"; cpu(1, 'h0021); step(2);
      cur = "R9"; cpu(0, 'h0010); cpu(1, 'h0099); step();
      cur = "R5"; ext_inv_ack = 1; step(); ext_inv_ack = 0; step();
      cur = "R7"; probe(0, 'h0029); probe(1, 'h0021);
      cur = "R8"; probe(0, 'h0021); step();

      cur = "R4"; cpu(1, 'h0032); step(2); fill(1); step(); probe(0, 'h0032);
      cur = "R6"; cpu(0, 'h0043); step(); fill(0); step();
      cpu(1, 'h0043); step(); cpu(0, 'h0043); cpu(0, 'h0010); step();
      cur = "R7"; probe(0, 'h0043);

      cur = "R9"; cpu_valid = 1; cpu_store = 0; cpu_addr = 16'h0010;
      ivn_valid = 1; ivn_addr = 16'h0055; step();
      ivn_valid = 0; cpu_valid = 0; step();

      cur = "R10"; cpu(0, 'h0054); step(); fill(1); step();
      cpu(1, 'h0054); step(2);
      probe(1, 'h0054); step(2);
      fill(0); step(); probe(0, 'h0054);

      cur = "R3"; cpu(0, 'h0090); step(); fill(0); step(); probe(0, 'h0010); probe(0, 'h0090);
      step(3);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         total++; bad++;
         $display("FAIL watchdog run did not end actual=0 expected=1");
         finish_run();
      end
   end
endmodule